// File: doc/BRIEF.md
# Dual-User EDAC Bus Router

This block places a single-error-correcting, double-error-detecting code between two 16-bit user ports (A and B) and one protected memory port. A path input picks either a memory access or a direct user-to-user transfer that bypasses memory. A master-select input names the user that owns the current transaction. Only that user's direction and select strobes decide what happens. The other user may switch on its own port to listen to the same data.

On a memory write, the master's word goes to the memory data bus. Six check bits generated from that word go to the memory check bus. On a memory read, the word and check bits from memory are decoded. The master receives one of three results: the corrected word, the raw word, or a diagnostic word carrying the syndrome and the stored check bits. Two error flags report the decode result. A valid qualifier marks the cycles in which the flags mean something.

The control decode is registered in a four-state machine:
- `ST_IDLE`: nothing is driven.
- `ST_WRITE`: memory write.
- `ST_READ`: memory read.
- `ST_XFER`: user-to-user transfer.

Every cycle the next state is chosen from the live strobes:
- Master select inactive: go to `ST_IDLE`.
- Memory path with read direction: go to `ST_READ`.
- Memory path with write direction: go to `ST_WRITE`.
- Transfer path with write direction: go to `ST_XFER`.
- Transfer path with read direction: go to `ST_IDLE`.

Any state can move to any other on the next clock. Reset forces `ST_IDLE`.

Top module: `dual_edac_router`

## Requirements
- R1: While reset is asserted and after it is released with no select active, `a_drive`, `b_drive`, `mem_drive`, `flag_valid`, `err_fix` and `err_fatal` are all 0.
- R2: One clock edge after the strobes are applied, the state follows the master's strobes: `master_sel`=0 makes A the master and 1 makes B the master. Strobes are active high and a direction of 1 means read. Master select inactive gives idle. `path_mem`=1 gives read or write by direction. `path_mem`=0 with write direction gives a transfer, and with read direction gives idle. The non-master's direction strobe has no effect on any output.
- R3: In the write state `mem_drive`=1, `mem_dout` equals the master's input word, and `mem_cout` is the XOR of the column codes of the set data bits. The column code for data bit i is the i-th value, counting from 0, in the ascending list of 6-bit numbers with exactly three ones: 07,0B,0D,0E,13,15,16,19,1A,1C,23,25,26,29,2A,2C hex.
- R4: In the read state the syndrome is the generated check bits of `mem_din` XOR `mem_cin`. A syndrome equal to data bit i's column code sets `err_fix`. With `fix_en`=1 the returned word has bit i inverted.
- R5: A syndrome with exactly one bit set (a check-bit error) sets `err_fix` and returns the memory word unchanged.
- R6: Any other nonzero syndrome sets `err_fatal` and returns the memory word unchanged. `err_fix` and `err_fatal` are never both 1.
- R7: With `fix_en`=0 the returned word is always the raw memory word, and the flags still report the decode.
- R8: With `diag_sel`=1 the read word is {2'b0, syndrome[5:0], 2'b0, mem_cin[5:0]}: the syndrome in the high byte and the stored check bits in the low byte.
- R9: During read, write and transfer states, the non-master's port is driven exactly when its own select and output enable are both 1. Its output carries the same word the transaction moves: the read result or the master's input word.
- R10: In the transfer state the non-master port receives the master's input word and `mem_drive` is 0. `mem_drive` is 0 in every state except write.
- R11: `flag_valid` is 1 only in the read state. Outside it `err_fix` and `err_fatal` are 0.
- R12: The master's port is driven only in the read state and only when its output enable is 1. The block never drives a user port while that user is writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| path_mem | input | 1 | 1 = memory access, 0 = user-to-user transfer |
| master_sel | input | 1 | 0 = user A is master, 1 = user B is master |
| fix_en | input | 1 | 1 = correct single data-bit errors on read |
| diag_sel | input | 1 | 1 = read returns syndrome and check bits |
| a_rw | input | 1 | User A direction, 1 = read |
| a_sel | input | 1 | User A select |
| a_oe | input | 1 | User A output enable |
| b_rw | input | 1 | User B direction, 1 = read |
| b_sel | input | 1 | User B select |
| b_oe | input | 1 | User B output enable |
| a_din | input | 16 | Word from user A |
| a_dout | output | 16 | Word toward user A |
| a_drive | output | 1 | Drive enable for user A bus |
| b_din | input | 16 | Word from user B |
| b_dout | output | 16 | Word toward user B |
| b_drive | output | 1 | Drive enable for user B bus |
| mem_din | input | 16 | Data word read from memory |
| mem_cin | input | 6 | Check bits read from memory |
| mem_dout | output | 16 | Data word to memory |
| mem_cout | output | 6 | Check bits to memory |
| mem_drive | output | 1 | Drive enable for memory buses |
| err_fix | output | 1 | Correctable error flag |
| err_fatal | output | 1 | Uncorrectable error flag |
| flag_valid | output | 1 | Error flags are meaningful |

## Verification
The strobes pass through one state register, so the drive enables, `flag_valid` and the state-dependent output selection are due one clock edge after the strobes are applied. The data outputs, check bits and flags are combinational from the data inputs once that state is in place. Each vector is therefore applied shortly after a rising edge, and every output is sampled five nanoseconds after the following rising edge. This is a single register stage later, with inputs held stable in between. The control sweep covers all 256 combinations of path, master and the six user strobes. The data sweeps cover every single data-bit and check-bit error, adjacent double errors, and the detect and diagnostic modes.

// File: rtl/edac_router_pkg.sv
package edac_router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_XFER  = 2'd3
    } route_st_e;

    // idx-th value (ascending) among cw-bit numbers of weight three
    function automatic logic [7:0] col_code(input int idx, input int cw);
        int n;
        logic [7:0] res;
        n   = 0;
        res = '0;
        for (int v = 0; v < 256; v++) begin
            if (v < (1 << cw) && $countones(v) == 3) begin
                if (n == idx) res = 8'(v);
                n++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/edac_chk_gen.sv
module edac_chk_gen
    import edac_router_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic [DW-1:0] d,
    output logic [CW-1:0] c
);
    always_comb begin
        logic [7:0] code;
        c = '0;
        for (int i = 0; i < DW; i++) begin
            code = col_code(i, CW);
            if (d[i]) c ^= code[CW-1:0];
        end
    end
endmodule

// File: rtl/edac_syn_dec.sv
module edac_syn_dec
    import edac_router_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic [DW-1:0] d,
    input  logic [CW-1:0] c,
    input  logic          fix_en,
    input  logic          diag_sel,
    output logic [DW-1:0] word,
    output logic          err_fix,
    output logic          err_fatal
);
    localparam int HW = DW / 2;

    logic [CW-1:0] regen;
    logic [CW-1:0] syn;
    logic [DW-1:0] flip;
    logic          chk_hit;

    edac_chk_gen #(.DW(DW), .CW(CW)) u_regen (.d(d), .c(regen));

    assign syn = regen ^ c;

    always_comb begin
        logic [7:0] code;
        for (int i = 0; i < DW; i++) begin
            code    = col_code(i, CW);
            flip[i] = (syn == code[CW-1:0]);
        end
    end

    assign chk_hit   = ($countones(syn) == 1);
    assign err_fix   = (|flip) || chk_hit;
    assign err_fatal = (syn != '0) && !err_fix;

    always_comb begin
        if (diag_sel)
            word = {{(HW-CW){1'b0}}, syn, {(HW-CW){1'b0}}, c};
        else if (fix_en)
            word = d ^ flip;
        else
            word = d;
    end
endmodule

// File: rtl/edac_route_fsm.sv
module edac_route_fsm
    import edac_router_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      path_mem,
    input  logic      master_sel,
    input  logic      a_rw,
    input  logic      a_sel,
    input  logic      a_oe,
    input  logic      b_rw,
    input  logic      b_sel,
    input  logic      b_oe,
    output route_st_e st,
    output logic      msel_q,
    output logic      a_drive,
    output logic      b_drive,
    output logic      mem_drive,
    output logic      flag_valid
);
    route_st_e nxt;
    logic      m_rw, m_sel;
    logic      a_en_q, b_en_q;

    assign m_rw  = master_sel ? b_rw  : a_rw;
    assign m_sel = master_sel ? b_sel : a_sel;

    always_comb begin
        unique case ({m_sel, path_mem, m_rw})
            3'b110:  nxt = ST_WRITE;
            3'b111:  nxt = ST_READ;
            3'b100:  nxt = ST_XFER;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            msel_q <= 1'b0;
            a_en_q <= 1'b0;
            b_en_q <= 1'b0;
        end else begin
            st     <= nxt;
            msel_q <= master_sel;
            a_en_q <= a_sel && a_oe;
            b_en_q <= b_sel && b_oe;
        end
    end

    always_comb begin
        a_drive    = 1'b0;
        b_drive    = 1'b0;
        mem_drive  = 1'b0;
        flag_valid = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_WRITE: begin
                mem_drive = 1'b1;
                if (msel_q) a_drive = a_en_q;
                else        b_drive = b_en_q;
            end
            ST_READ: begin
                flag_valid = 1'b1;
                a_drive    = a_en_q;
                b_drive    = b_en_q;
            end
            ST_XFER: begin
                if (msel_q) a_drive = a_en_q;
                else        b_drive = b_en_q;
            end
        endcase
    end

    assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> !(a_drive && b_drive));

    assert_write_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (path_mem && !master_sel && a_sel && !a_rw) |=> mem_drive);

    assert_bypass_nomem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !path_mem |=> !mem_drive);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !(a_drive || b_drive || mem_drive || flag_valid));
endmodule

// File: rtl/dual_edac_router.sv
module dual_edac_router
    import edac_router_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          path_mem,
    input  logic          master_sel,
    input  logic          fix_en,
    input  logic          diag_sel,
    input  logic          a_rw,
    input  logic          a_sel,
    input  logic          a_oe,
    input  logic          b_rw,
    input  logic          b_sel,
    input  logic          b_oe,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    output logic          a_drive,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout,
    output logic          b_drive,
    input  logic [DW-1:0] mem_din,
    input  logic [CW-1:0] mem_cin,
    output logic [DW-1:0] mem_dout,
    output logic [CW-1:0] mem_cout,
    output logic          mem_drive,
    output logic          err_fix,
    output logic          err_fatal,
    output logic          flag_valid
);
    route_st_e     st;
    logic          msel_q;
    logic [DW-1:0] mstr_word;
    logic [DW-1:0] rd_word;
    logic          dec_fix, dec_fatal;
    logic [DW-1:0] out_word;

    edac_route_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .path_mem(path_mem), .master_sel(master_sel),
        .a_rw(a_rw), .a_sel(a_sel), .a_oe(a_oe),
        .b_rw(b_rw), .b_sel(b_sel), .b_oe(b_oe),
        .st(st), .msel_q(msel_q),
        .a_drive(a_drive), .b_drive(b_drive),
        .mem_drive(mem_drive), .flag_valid(flag_valid)
    );

    assign mstr_word = msel_q ? b_din : a_din;

    edac_chk_gen #(.DW(DW), .CW(CW)) u_gen (.d(mstr_word), .c(mem_cout));

    edac_syn_dec #(.DW(DW), .CW(CW)) u_dec (
        .d(mem_din), .c(mem_cin), .fix_en(fix_en), .diag_sel(diag_sel),
        .word(rd_word), .err_fix(dec_fix), .err_fatal(dec_fatal)
    );

    assign mem_dout  = mstr_word;
    assign out_word  = (st == ST_READ) ? rd_word : mstr_word;
    assign a_dout    = out_word;
    assign b_dout    = out_word;
    assign err_fix   = flag_valid && dec_fix;
    assign err_fatal = flag_valid && dec_fatal;

    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fix && err_fatal));

    assert_read_nomem_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |-> !mem_drive);
endmodule

// File: tb/sim_dual_edac_router.sv
module sim_dual_edac_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic path_mem = 0, master_sel = 0, fix_en = 1, diag_sel = 0;
    logic a_rw = 0, a_sel = 0, a_oe = 0, b_rw = 0, b_sel = 0, b_oe = 0;
    logic [15:0] a_din = 16'hA5C3, b_din = 16'h3C5A, mem_din = 16'h0;
    logic [5:0]  mem_cin = 6'h0;
    logic [15:0] a_dout, b_dout, mem_dout;
    logic [5:0]  mem_cout;
    logic a_drive, b_drive, mem_drive, err_fix, err_fatal, flag_valid;

    int checks = 0, fails = 0;
    bit done = 0;

    localparam logic [5:0] CODES [16] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15,
        6'h16, 6'h19, 6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C};

    always #10 clk = ~clk;

    dual_edac_router u0 (
        .clk(clk), .rst_n(rst_n), .path_mem(path_mem), .master_sel(master_sel),
        .fix_en(fix_en), .diag_sel(diag_sel),
        .a_rw(a_rw), .a_sel(a_sel), .a_oe(a_oe), .b_rw(b_rw), .b_sel(b_sel), .b_oe(b_oe),
        .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive),
        .mem_din(mem_din), .mem_cin(mem_cin), .mem_dout(mem_dout), .mem_cout(mem_cout),
        .mem_drive(mem_drive), .err_fix(err_fix), .err_fatal(err_fatal),
        .flag_valid(flag_valid)
    );

    function automatic logic [5:0] chk_of(input logic [15:0] d);
        logic [5:0] r = '0;
        for (int i = 0; i < 16; i++) if (d[i]) r ^= CODES[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ctl = {path, msel, a_rw, a_sel, a_oe, b_rw, b_sel, b_oe}
    task automatic apply(input logic [7:0] ctl);
        {path_mem, master_sel, a_rw, a_sel, a_oe, b_rw, b_sel, b_oe} = ctl;
        @(posedge clk);
        #5;
    endtask

    task automatic check_read(input string req, input logic [15:0] exp_word,
                              input logic exp_fix, input logic exp_fatal);
        chk({req, " word"}, {16'h0, a_dout}, {16'h0, exp_word});
        chk({req, " listen R9"}, {16'h0, b_dout}, {16'h0, exp_word});
        chk({req, " flags"}, {29'h0, flag_valid, err_fix, err_fatal}, {29'h0, 1'b1, exp_fix, exp_fatal});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] words [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001};
        repeat (3) @(posedge clk);
        #5;
        // R1 during reset
        chk("R1 in reset", {28'h0, a_drive, b_drive, mem_drive, flag_valid}, 32'h0);
        chk("R1 flags in reset", {30'h0, err_fix, err_fatal}, 32'h0);
        rst_n = 1'b1;
        apply(8'h00);
        chk("R1 after reset", {28'h0, a_drive, b_drive, mem_drive, flag_valid}, 32'h0);

        // Full control sweep: R2 R9 R10 R11 R12
        mem_din = 16'h5AA5;
        mem_cin = chk_of(16'h5AA5);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] c = 8'(v);
            logic p = c[7], ms = c[6];
            logic m_rw = ms ? c[2] : c[5];
            logic m_sl = ms ? c[1] : c[4];
            logic l_en = ms ? (c[4] && c[3]) : (c[1] && c[0]);
            logic m_oe = ms ? c[0] : c[3];
            int   est;
            logic e_a, e_b, e_m, e_f;
            logic [15:0] mw;
            if (!m_sl) est = 0;
            else if (p) est = m_rw ? 2 : 1;
            else est = m_rw ? 0 : 3;
            e_m = (est == 1);
            e_f = (est == 2);
            e_a = 0; e_b = 0;
            if (est != 0) begin
                if (ms) e_a = l_en; else e_b = l_en;
            end
            if (est == 2) begin
                if (ms) e_b = m_oe; else e_a = m_oe;
            end
            apply(c);
            chk($sformatf("R2 R12 drives ctl=%h", c),
                {28'h0, a_drive, b_drive, mem_drive, flag_valid}, {28'h0, e_a, e_b, e_m, e_f});
            chk($sformatf("R11 flags ctl=%h", c), {30'h0, err_fix, err_fatal}, 32'h0);
            mw = ms ? b_din : a_din;
            if (e_a) chk($sformatf("R9 R10 a word ctl=%h", c), {16'h0, a_dout},
                         {16'h0, (est == 2) ? 16'h5AA5 : mw});
            if (e_b) chk($sformatf("R9 R10 b word ctl=%h", c), {16'h0, b_dout},
                         {16'h0, (est == 2) ? 16'h5AA5 : mw});
        end

        // Writes: R3, master B with A listening, then master A
        foreach (words[k]) begin
            b_din = words[k];
            apply(8'b1_1_0_1_1_0_1_0);
            chk("R3 mem data", {16'h0, mem_dout}, {16'h0, words[k]});
            chk("R3 check bits", {26'h0, mem_cout}, {26'h0, chk_of(words[k])});
            chk("R9 write listen", {15'h0, a_drive, a_dout}, {15'h0, 1'b1, words[k]});
            a_din = ~words[k];
            apply(8'b1_0_0_1_0_0_0_0);
            chk("R3 master A data", {10'h0, mem_cout, mem_dout},
                {10'h0, chk_of(~words[k]), ~words[k]});
        end

        // Transfers: R10
        a_din = 16'hC0DE;
        apply(8'b0_0_0_1_0_1_1_1);
        chk("R10 A to B", {14'h0, mem_drive, b_drive, b_dout}, {14'h0, 1'b0, 1'b1, 16'hC0DE});
        b_din = 16'hBEEF;
        apply(8'b0_1_1_1_1_0_1_0);
        chk("R10 B to A", {14'h0, mem_drive, a_drive, a_dout}, {14'h0, 1'b0, 1'b1, 16'hBEEF});

        // Reads: master A with B listening
        foreach (words[k]) begin
            logic [15:0] w = words[k];
            logic [5:0]  cb = chk_of(w);
            fix_en = 1; diag_sel = 0;
            mem_din = w; mem_cin = cb;
            apply(8'b1_0_1_1_1_0_1_1);
            check_read("R4 clean", w, 0, 0);
            for (int i = 0; i < 16; i++) begin
                mem_din = w ^ (16'h1 << i); mem_cin = cb;
                apply(8'b1_0_1_1_1_0_1_1);
                check_read($sformatf("R4 data bit %0d", i), w, 1, 0);
            end
            for (int j = 0; j < 6; j++) begin
                mem_din = w; mem_cin = cb ^ (6'h1 << j);
                apply(8'b1_0_1_1_1_0_1_1);
                check_read($sformatf("R5 check bit %0d", j), w, 1, 0);
            end
            for (int i = 0; i < 15; i++) begin
                mem_din = w ^ (16'h3 << i); mem_cin = cb;
                apply(8'b1_0_1_1_1_0_1_1);
                check_read($sformatf("R6 double %0d", i), w ^ (16'h3 << i), 0, 1);
            end
            fix_en = 0;
            mem_din = w ^ 16'h0100; mem_cin = cb;
            apply(8'b1_0_1_1_1_0_1_1);
            check_read("R7 detect mode", w ^ 16'h0100, 1, 0);
            fix_en = 1; diag_sel = 1;
            mem_din = w ^ 16'h0010; mem_cin = cb;
            apply(8'b1_0_1_1_1_0_1_1);
            check_read("R8 diag word", {2'b0, chk_of(w ^ 16'h0010) ^ cb, 2'b0, cb}, 1, 0);
            diag_sel = 0;
        end

        // Master B read, A not listening (oe low): R12
        mem_din = 16'h1234 ^ 16'h8000; mem_cin = chk_of(16'h1234);
        apply(8'b1_1_0_1_0_1_1_1);
        chk("R12 B read", {14'h0, a_drive, b_drive, b_dout}, {14'h0, 1'b0, 1'b1, 16'h1234});

        apply(8'h00);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule